// File: doc/BRIEF.md
# Transceiver Operating-State Controller

This block decides which parts of a radio transceiver are powered and running. It holds one of six operating states: power-save, sleep, alert, receive, transmit and full-duplex. For the current state it drives enables for the synthesizers, the receive chain, the transmit chain, the baseband clocks and the baseband PLL. A host requests a new state with a one-cycle write strobe and a 3-bit state code. The request is issued in the host clock domain and carried into the feedback clock domain by a toggle handshake. As an alternative, a baseband processor can step the state in real time with two control pins. These are an enable pin and a direction pin, both synchronized into the feedback clock domain.

The pins work in one of two styles. In pulse style a rising edge on the enable pin toggles between alert and an active state. In level style the rising edge enters the active state and the falling edge leaves it. When full-duplex operation and the gate remap are both selected, the pins no longer change the state. They then act as direct on/off gates for the receive and transmit chains, and only host writes move the state. A host request for a transition the controller does not allow is dropped and raises a sticky error flag.

Top module: `trx_state_ctrl`

## Requirements
- R1: After reset the state is power-save (code 0): `clk_en`=1, `pll_en`=1, `synth_en`=0, `rx_en`=0, `tx_en`=0, `cmd_err`=0. The state codes are power-save=0, sleep=1, alert=2, receive=3, transmit=4, full-duplex=5.
- R2: The outputs decode the state as follows. Sleep turns everything off. Power-save has only the clocks and the PLL on. Alert adds the synthesizers. Receive adds the receive chain to alert. Transmit adds the transmit chain to alert. Full-duplex adds both chains to alert.
- R3: A host write takes effect a few feedback cycles after the strobe if the transition is allowed. A request for the current state is allowed. Sleep may go only to power-save. Power-save may go to sleep or alert. Alert may go to power-save, to receive or transmit when `cfg_duplex`=0, or to full-duplex when `cfg_duplex`=1. Receive, transmit and full-duplex may go only to alert.
- R4: A host write that is not allowed leaves the state unchanged and sets `cmd_err`. The flag stays set until reset. Codes 6 and 7 are never allowed. While the pins control the state, writes naming receive, transmit or full-duplex are not allowed.
- R5: Pulse style (`cfg_pin_ctl`=1, `cfg_level`=0): a rising edge on `en_pin` moves alert to the active state. The active state is full-duplex if `cfg_duplex`=1, transmit if `txnrx_pin`=1, and receive otherwise. The same edge moves an active state back to alert. In power-save and sleep the edge has no effect, and falling edges never have any effect.
- R6: Level style (`cfg_level`=1): a rising edge on `en_pin` moves alert to the active state chosen as in R5. A falling edge moves an active state back to alert.
- R7: In level style with `cfg_duplex`=0, a change of `txnrx_pin` while receiving or transmitting moves the state to transmit (pin high) or receive (pin low). In pulse style such a change has no effect.
- R8: An `en_pin` pulse that begins and ends between two consecutive `fclk` rising edges has no effect.
- R9: With `cfg_pin_ctl`=0 the pins never change the state.
- R10: With `cfg_duplex`=1 and `cfg_gate_remap`=1, the pins never change the state. In full-duplex, `rx_en` follows `en_pin` and `tx_en` follows `txnrx_pin` after synchronization. In every other state both chain enables stay 0.
- R11: If a host request and a pin edge are acted on in the same feedback cycle, the host request is applied and the pin edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Feedback clock; state register domain |
| frst_n | input | 1 | Active-low reset, fclk domain |
| hclk | input | 1 | Host write clock |
| hrst_n | input | 1 | Active-low reset, hclk domain |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_state | input | 3 | Requested state code |
| cfg_pin_ctl | input | 1 | 1: pins step the state |
| cfg_level | input | 1 | 1: level style, 0: pulse style |
| cfg_duplex | input | 1 | 1: active state is full-duplex |
| cfg_gate_remap | input | 1 | 1 with duplex: pins gate the chains |
| en_pin | input | 1 | Asynchronous enable control pin |
| txnrx_pin | input | 1 | Asynchronous direction / transmit gate pin |
| state | output | 3 | Current state code |
| synth_en | output | 1 | Synthesizer enable |
| rx_en | output | 1 | Receive chain enable |
| tx_en | output | 1 | Transmit chain enable |
| clk_en | output | 1 | Baseband clock enable |
| pll_en | output | 1 | Baseband PLL enable |
| cmd_err | output | 1 | Sticky illegal-request flag |

## Verification
A host request and an enable-pin edge can be acted on in the same feedback cycle. The bench runs both clock ports from one clock so that the latency of each path is known. Host writes take one cycle to be captured plus two synchronizer stages. The pin path has two synchronizer stages. The bench raises the pin one cycle after the write strobe so that both events land together. It does this from alert in pulse style with a request for power-save. The result passes if the state settles in power-save with no error flag: had the pin been honoured, the state would be receive or alert.

// File: rtl/trx_state_ctrl.sv
module trx_state_ctrl (
  input  logic       fclk,
  input  logic       frst_n,
  input  logic       hclk,
  input  logic       hrst_n,
  input  logic       wr_stb,
  input  logic [2:0] wr_state,
  input  logic       cfg_pin_ctl,
  input  logic       cfg_level,
  input  logic       cfg_duplex,
  input  logic       cfg_gate_remap,
  input  logic       en_pin,
  input  logic       txnrx_pin,
  output logic [2:0] state,
  output logic       synth_en,
  output logic       rx_en,
  output logic       tx_en,
  output logic       clk_en,
  output logic       pll_en,
  output logic       cmd_err
);
  localparam logic [2:0] S_PSAVE = 3'd0, S_SLEEP = 3'd1, S_ALERT = 3'd2,
                         S_RX = 3'd3, S_TX = 3'd4, S_DUPLEX = 3'd5;

  function automatic logic step_ok(input logic [2:0] cur, input logic [2:0] nxt,
                                   input logic duplex, input logic pinctl);
    if (nxt > S_DUPLEX)                return 1'b0;
    if (nxt == cur)                    return 1'b1;
    if (pinctl && nxt >= S_RX)         return 1'b0;
    case (cur)
      S_SLEEP: return nxt == S_PSAVE;
      S_PSAVE: return nxt == S_SLEEP || nxt == S_ALERT;
      S_ALERT: return nxt == S_PSAVE || (!duplex && (nxt == S_RX || nxt == S_TX))
                      || (duplex && nxt == S_DUPLEX);
      default: return nxt == S_ALERT;
    endcase
  endfunction

  // host side: capture request, flip toggle
  logic       h_tog;
  logic [2:0] h_req;
  always_ff @(posedge hclk or negedge hrst_n)
    if (!hrst_n) begin
      h_tog <= 1'b0;
      h_req <= S_PSAVE;
    end else if (wr_stb) begin
      h_tog <= ~h_tog;
      h_req <= wr_state;
    end

  // feedback side synchronizers
  logic [2:0] tog_q;
  logic [2:0] en_q, tx_q;
  always_ff @(posedge fclk or negedge frst_n)
    if (!frst_n) begin
      tog_q <= '0;
      en_q  <= '0;
      tx_q  <= '0;
    end else begin
      tog_q <= {tog_q[1:0], h_tog};
      en_q  <= {en_q[1:0], en_pin};
      tx_q  <= {tx_q[1:0], txnrx_pin};
    end

  wire cmd_v   = tog_q[1] ^ tog_q[2];
  wire en_s    = en_q[1];
  wire tx_s    = tx_q[1];
  wire en_rise = en_s & ~en_q[2];
  wire en_fall = ~en_s & en_q[2];
  wire tx_edge = tx_s ^ tx_q[2];
  wire remap   = cfg_duplex & cfg_gate_remap;
  wire pin_ctl = cfg_pin_ctl & ~remap;
  wire active  = state == S_RX || state == S_TX || state == S_DUPLEX;
  wire [2:0] tgt = cfg_duplex ? S_DUPLEX : (tx_s ? S_TX : S_RX);

  logic [2:0] nxt;
  logic       err_set;
  always_comb begin
    nxt     = state;
    err_set = 1'b0;
    if (cmd_v) begin
      if (step_ok(state, h_req, cfg_duplex, pin_ctl)) nxt = h_req;
      else err_set = 1'b1;
    end else if (pin_ctl) begin
      if (!cfg_level) begin
        if (en_rise && state == S_ALERT) nxt = tgt;
        else if (en_rise && active)      nxt = S_ALERT;
      end else begin
        if (en_rise && state == S_ALERT) nxt = tgt;
        else if (en_fall && active)      nxt = S_ALERT;
        else if (tx_edge && !cfg_duplex && (state == S_RX || state == S_TX))
          nxt = tx_s ? S_TX : S_RX;
      end
    end
  end

  always_ff @(posedge fclk or negedge frst_n)
    if (!frst_n) begin
      state   <= S_PSAVE;
      cmd_err <= 1'b0;
    end else begin
      state   <= nxt;
      cmd_err <= cmd_err | err_set;
    end

  assign clk_en   = state != S_SLEEP;
  assign pll_en   = state != S_SLEEP;
  assign synth_en = state == S_ALERT || active;
  assign rx_en    = (state == S_RX || state == S_DUPLEX) & (~remap | en_s);
  assign tx_en    = (state == S_TX || state == S_DUPLEX) & (~remap | tx_s);

  // R4
  err_sticky_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    cmd_err |=> cmd_err);
  // R3
  sleep_exit_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    (state == S_SLEEP && nxt != S_SLEEP) |=> state == S_PSAVE);
  // R9
  pins_idle_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    (!cfg_pin_ctl && !cmd_v) |=> $stable(state));
  // R10
  remap_hold_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    (remap && !cmd_v) |=> $stable(state));
  // R2
  chain_synth_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    (rx_en || tx_en) |-> (synth_en && clk_en));
  // R4
  bad_code_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    (cmd_v && h_req > S_DUPLEX) |=> (cmd_err && $stable(state)));
endmodule

// File: tb/trx_state_ctrl_test.sv
`timescale 1ns/1ps
module trx_state_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic wr_stb = 0;
  logic [2:0] wr_state = 0;
  logic cfg_pin_ctl = 0, cfg_level = 0, cfg_duplex = 0, cfg_gate_remap = 0;
  logic en_pin = 0, txnrx_pin = 0;
  logic [2:0] state;
  logic synth_en, rx_en, tx_en, clk_en, pll_en, cmd_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trx_state_ctrl uut (
    .fclk(clk), .frst_n(rst_n), .hclk(clk), .hrst_n(rst_n),
    .wr_stb(wr_stb), .wr_state(wr_state),
    .cfg_pin_ctl(cfg_pin_ctl), .cfg_level(cfg_level), .cfg_duplex(cfg_duplex),
    .cfg_gate_remap(cfg_gate_remap), .en_pin(en_pin), .txnrx_pin(txnrx_pin),
    .state(state), .synth_en(synth_en), .rx_en(rx_en), .tx_en(tx_en),
    .clk_en(clk_en), .pll_en(pll_en), .cmd_err(cmd_err));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit allowed(int f, int t, bit dup, bit pinctl);
    if (t > 5) return 0;
    if (t == f) return 1;
    if (pinctl && t >= 3) return 0;
    case (f)
      1: return t == 0;
      0: return t == 1 || t == 2;
      2: return t == 0 || (!dup && (t == 3 || t == 4)) || (dup && t == 5);
      default: return t == 2;
    endcase
  endfunction

  // {clk,pll,synth,rx,tx}
  function automatic int outs(int s);
    case (s)
      1: return 5'b00000;
      0: return 5'b11000;
      2: return 5'b11100;
      3: return 5'b11110;
      4: return 5'b11101;
      default: return 5'b11111;
    endcase
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wait_n(3); rst_n = 1; wait_n(2);
  endtask

  task automatic wr(int s);
    @(negedge clk); wr_stb = 1; wr_state = 3'(s);
    @(negedge clk); wr_stb = 0;
    wait_n(5);
  endtask

  task automatic set_en(bit v); @(negedge clk); en_pin = v; wait_n(5); endtask
  task automatic set_tx(bit v); @(negedge clk); txnrx_pin = v; wait_n(5); endtask
  task automatic pulse(); set_en(1); set_en(0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk("R1 state", state, 0);
    chk("R1 outs", {clk_en, pll_en, synth_en, rx_en, tx_en}, 5'b11000);
    chk("R1 err", cmd_err, 0);

    // R3 R4 R2 sweep over register transitions
    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 6; f++)
        for (int t = 0; t < 8; t++) begin
          if ((d == 1 && (f == 3 || f == 4)) || (d == 0 && f == 5)) continue;
          do_reset();
          cfg_pin_ctl = 0; cfg_duplex = d[0]; cfg_gate_remap = 0;
          if (f == 1) wr(1);
          if (f >= 2) wr(2);
          if (f >= 3) wr(f);
          chk("R3 setup", state, f);
          wr(t);
          if (allowed(f, t, d[0], 0)) begin
            chk("R3 move", state, t);
            chk("R4 noerr", cmd_err, 0);
          end else begin
            chk("R4 hold", state, f);
            chk("R4 err", cmd_err, 1);
          end
          chk("R2 decode", {clk_en, pll_en, synth_en, rx_en, tx_en}, outs(state));
        end

    // R5 pulse style
    do_reset(); cfg_duplex = 0; cfg_pin_ctl = 1; cfg_level = 0;
    wr(2);
    pulse(); chk("R5 to rx", state, 3);
    pulse(); chk("R5 back", state, 2);
    set_tx(1); pulse(); chk("R5 to tx", state, 4);
    set_tx(0); chk("R7 pulse no dir change", state, 4);
    pulse(); chk("R5 back2", state, 2);
    // R4 pin mode rejects active target
    wr(3); chk("R4 pin reject", state, 2); chk("R4 pin err", cmd_err, 1);
    // R8 glitch
    @(negedge clk); #1 en_pin = 1; #2 en_pin = 0; wait_n(5);
    chk("R8 glitch", state, 2);
    wr(0); pulse(); chk("R5 psave no effect", state, 0);
    cfg_duplex = 1; wr(2); pulse(); chk("R5 duplex", state, 5);
    pulse(); chk("R5 duplex back", state, 2);

    // R6 R7 level style
    do_reset(); cfg_duplex = 0; cfg_pin_ctl = 1; cfg_level = 1;
    wr(2);
    set_en(1); chk("R6 rise", state, 3);
    set_tx(1); chk("R7 to tx", state, 4);
    set_tx(0); chk("R7 to rx", state, 3);
    set_en(0); chk("R6 fall", state, 2);
    set_tx(1); set_en(1); chk("R6 rise tx", state, 4);
    set_en(0); chk("R6 fall tx", state, 2);
    set_tx(0);
    cfg_duplex = 1; set_en(1); chk("R6 duplex", state, 5);
    set_en(0); chk("R6 duplex fall", state, 2);

    // R9 pins ignored in register mode
    do_reset(); cfg_pin_ctl = 0; cfg_level = 0; cfg_duplex = 0;
    wr(2); pulse(); chk("R9 pulse ignored", state, 2);
    set_tx(1); set_en(1); chk("R9 level ignored", state, 2);
    set_en(0); set_tx(0);

    // R10 remap gating
    do_reset(); cfg_pin_ctl = 1; cfg_duplex = 1; cfg_gate_remap = 1;
    wr(2); set_en(1); chk("R10 alert gate rx", rx_en, 0); chk("R10 no move", state, 2);
    set_en(0);
    wr(5);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); en_pin = p[0]; txnrx_pin = p[1]; wait_n(4);
      chk("R10 rx gate", rx_en, p[0]);
      chk("R10 tx gate", tx_en, p[1]);
      chk("R10 state", state, 5);
    end
    @(negedge clk); en_pin = 0; txnrx_pin = 0; wait_n(4);

    // R11 same-cycle collision
    do_reset(); cfg_pin_ctl = 1; cfg_level = 0; cfg_duplex = 0; cfg_gate_remap = 0;
    wr(2);
    @(negedge clk); wr_stb = 1; wr_state = 3'd0;
    @(negedge clk); wr_stb = 0; en_pin = 1;
    wait_n(3); en_pin = 0; wait_n(4);
    chk("R11 host wins", state, 0);
    chk("R11 no err", cmd_err, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule